// File: doc/BRIEF.md
# Virtually Indexed Write-Through Line Cache

This block sits between a 32-bit processor and a word-wide main-memory port. It is a direct-mapped cache that is indexed and tagged by the virtual address. Each line's tag also records the context that filled it and the write and supervisor permissions the page had at fill time. A load that hits is answered from the cache. A load that misses drops the resident line and fetches all four words of the new line before it answers. Every permitted store goes out to memory. A store that hits also updates the cached word. A store that misses clears the indexed line's valid bit and leaves it empty.

Software reaches the raw tag words through a control-space port, one line per access. It must clear every tag before it raises the enable input. While enable is low, every access goes straight to memory and the tags are left alone. A combinational helper flags two virtual addresses that would sit in different lines although they share the same page offset.

Top module: `vac_cache`

## Requirements
- R1: A read hits when the indexed line is valid, its stored tag ID equals `cpu_addr[29:16]` and its stored context equals `cpu_ctx`. The line index is `cpu_addr[15:4]` and `cpu_addr[3:2]` selects the word. A hit returns the cached word with no memory transaction. A context mismatch counts as a miss.
- R2: A read miss first invalidates the slot. It then performs exactly four memory reads of the line's words at byte offsets 0, 4, 8 and 12, in that order. Afterwards the slot holds valid=1, the request's tag ID and context, and the page write and supervisor flags. The requested word is returned only after the last fill word arrives.
- R3: Every store that does not fault performs exactly one memory write of `cpu_wdata` to the word address. When it hits, the cached word is updated as well, so a later read hit returns the stored value without memory traffic.
- R4: A store that misses clears the valid bit of the indexed slot and does not allocate it. A later read of the line that used to occupy the slot therefore misses.
- R5: A store that hits a line whose write flag is 0, or a user-mode access (`cpu_super`=0) that hits a line whose supervisor flag is 1, ends with `cpu_fault` and `cpu_ready` high for one cycle. Such an access makes no memory transaction and changes no tag or data.
- R6: While `cache_en` is 0, every access makes exactly one memory transaction, returns memory data for reads, never faults and leaves all tags unchanged.
- R7: Tag words use this layout: bits 24:22 context, bit 21 write flag, bit 20 supervisor flag, bit 19 valid, bits 15:2 tag ID. A read through the control port returns the addressed tag in the next cycle with every other bit 0. Bits written outside those fields are discarded.
- R8: `alias_hit` is 1 exactly when `alias_a` and `alias_b` differ in any of bits 15:12.
- R9: After reset, `cpu_ready`, `cpu_fault` and `mem_req` are low and `cs_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Cache enable; 0 sends every access to memory |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Word-aligned virtual address |
| cpu_wdata | input | 32 | Store data |
| cpu_ctx | input | 3 | Current context |
| cpu_super | input | 1 | Requester is in supervisor mode |
| pte_wr | input | 1 | Page write permission, recorded on fill |
| pte_sup | input | 1 | Page supervisor-only flag, recorded on fill |
| cpu_ready | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_fault | output | 1 | Protection fault, valid with `cpu_ready` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes one word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| cs_we | input | 1 | Tag port write strobe |
| cs_re | input | 1 | Tag port read strobe |
| cs_idx | input | 12 | Tag port line index |
| cs_wdata | input | 32 | Raw tag word to write |
| cs_rdata | output | 32 | Raw tag word read, one cycle after `cs_re` |
| alias_a | input | 32 | First address for the alias check |
| alias_b | input | 32 | Second address for the alias check |
| alias_hit | output | 1 | Addresses fall in different lines for the same page offset |

## Verification
The embedded properties check several behaviours on every cycle. A memory request keeps its address and direction until it is acknowledged. Fill addresses climb one word per acknowledgement. A fault is a single-cycle completion that makes no memory request and no tag or data update. A disabled lookup never touches the arrays. Other results depend on the history of the tags, so only the bench's scenarios can show them: which accesses hit, the resulting memory traffic counts, data coherence after stores, invalidation by a store miss, fault selection, and the tag contents read back through the control port. The bench checks these against a reference model of tags and memory.

// File: rtl/vac_pkg.sv
// Package: shared geometry, tag record and tag-word conversions for the
// virtually indexed cache. Assumes word-aligned 32-bit accesses.
package vac_pkg;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int TID_W    = 14;
    localparam int IDX_W    = 12;
    localparam int OFS_W    = 4;
    localparam int CTX_W    = 3;
    localparam int BYTE_W   = 2;                  // byte-in-word bits
    localparam int WSEL_W   = OFS_W - BYTE_W;     // word-in-line bits
    localparam int WPL      = 2 ** WSEL_W;        // words per line
    localparam int NLINES   = 2 ** IDX_W;
    localparam int IDX_LO   = OFS_W;
    localparam int TID_LO   = OFS_W + IDX_W;
    localparam int PAGE_W   = 12;                 // page offset bits
    // Raw tag word field positions (control-space view)
    localparam int TW_TID_LO = 2;
    localparam int TW_VALID  = 19;
    localparam int TW_SUP    = 20;
    localparam int TW_WR     = 21;
    localparam int TW_CTX_LO = 22;

    typedef struct packed {
        logic             valid;
        logic [CTX_W-1:0] ctx;
        logic             wr;
        logic             sup;
        logic [TID_W-1:0] tid;
    } tag_t;

    // Format a stored tag as a raw word, unused fields zero.
    function automatic logic [DATA_W-1:0] tag_to_word(tag_t t);
        logic [DATA_W-1:0] w;
        w = '0;
        w[TW_TID_LO +: TID_W] = t.tid;
        w[TW_VALID]           = t.valid;
        w[TW_SUP]             = t.sup;
        w[TW_WR]              = t.wr;
        w[TW_CTX_LO +: CTX_W] = t.ctx;
        return w;
    endfunction

    // Extract the meaningful fields of a raw word; others are dropped.
    function automatic tag_t word_to_tag(logic [DATA_W-1:0] w);
        tag_t t;
        t.tid   = w[TW_TID_LO +: TID_W];
        t.valid = w[TW_VALID];
        t.sup   = w[TW_SUP];
        t.wr    = w[TW_WR];
        t.ctx   = w[TW_CTX_LO +: CTX_W];
        return t;
    endfunction
endpackage

// File: rtl/vac_tag_store.sv
// Tag array: one tag record per line. Combinational lookup port for the
// controller, one update port from the controller, and a control-space
// port with registered read. Control-space writes win over updates;
// software is assumed to use that port only while the CPU is quiet.
module vac_tag_store
    import vac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output tag_t              lk_tag,
    input  logic              upd_we,
    input  logic [IDX_W-1:0]  upd_idx,
    input  tag_t              upd_tag,
    input  logic              cs_we,
    input  logic              cs_re,
    input  logic [IDX_W-1:0]  cs_idx,
    input  logic [DATA_W-1:0] cs_wdata,
    output logic [DATA_W-1:0] cs_rdata
);
    tag_t tags [NLINES];
    logic cs_wdata_unused;

    assign cs_wdata_unused = ^cs_wdata;

    // Write a tag from the control port or from the controller.
    always_ff @(posedge clk) begin
        if (cs_we) begin
            tags[cs_idx] <= word_to_tag(cs_wdata);
        end else if (upd_we) begin
            tags[upd_idx] <= upd_tag;
        end
    end

    // Lookup is combinational for single-cycle hit detection.
    assign lk_tag = tags[lk_idx];

    // Registered control-space read in raw word format.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_rdata <= '0;
        end else if (cs_re) begin
            cs_rdata <= tag_to_word(tags[cs_idx]);
        end
    end

    a_r7_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_re && !cs_we) |=> $stable(cs_rdata));
endmodule

// File: rtl/vac_data_store.sv
// Data array: one line of WPL words per index. Word write port from the
// controller, combinational word read port. Assumes no reset is needed:
// a line is only read after its tag marks it valid.
module vac_data_store
    import vac_pkg::*;
(
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WSEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0] rd_word,
    input  logic              we,
    input  logic [WSEL_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_word
);
    logic [WPL-1:0][DATA_W-1:0] lines [NLINES];

    // Store one word of the indexed line.
    always_ff @(posedge clk) begin
        if (we) begin
            lines[idx][wr_sel] <= wr_word;
        end
    end

    assign rd_word = lines[idx][rd_sel];
endmodule

// File: rtl/vac_ctrl.sv
// Cache controller: captures one CPU access, looks it up, and then answers
// it, refills the line, writes through, faults, or bypasses. The CPU holds
// cpu_req until cpu_ready; memory holds nothing, the controller holds
// mem_req and its address until mem_ack.
module vac_ctrl
    import vac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [CTX_W-1:0]  cpu_ctx,
    input  logic              cpu_super,
    input  logic              pte_wr,
    input  logic              pte_sup,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  line_idx,
    input  tag_t              lk_tag,
    output logic              upd_we,
    output tag_t              upd_tag,
    output logic [WSEL_W-1:0] rd_sel,
    input  logic [DATA_W-1:0] rd_word,
    output logic              dwe,
    output logic [WSEL_W-1:0] dw_sel,
    output logic [DATA_W-1:0] dw_data
);
    typedef enum logic [2:0] {S_IDLE, S_LOOK, S_REFILL, S_RESP, S_MEM} state_t;
    localparam logic [WSEL_W-1:0] LAST = WSEL_W'(WPL - 1);

    state_t             state_q, state_d;
    logic [ADDR_W-1:0]  a_q;
    logic [DATA_W-1:0]  wd_q;
    logic               we_q, sup_q, pw_q, ps_q;
    logic [CTX_W-1:0]   ctx_q;
    logic [WSEL_W-1:0]  cnt_q;
    logic [TID_W-1:0]   req_tid;
    logic               hit, viol;

    assign line_idx = a_q[IDX_LO +: IDX_W];
    assign req_tid  = a_q[TID_LO +: TID_W];
    assign rd_sel   = a_q[BYTE_W +: WSEL_W];

    assign hit  = lk_tag.valid && (lk_tag.tid == req_tid) && (lk_tag.ctx == ctx_q);
    assign viol = (we_q && !lk_tag.wr) || (!sup_q && lk_tag.sup);

    // Capture the request when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            wd_q  <= '0;
            we_q  <= 1'b0;
            sup_q <= 1'b0;
            pw_q  <= 1'b0;
            ps_q  <= 1'b0;
            ctx_q <= '0;
        end else if (state_q == S_IDLE && cpu_req) begin
            a_q   <= cpu_addr;
            wd_q  <= cpu_wdata;
            we_q  <= cpu_we;
            sup_q <= cpu_super;
            pw_q  <= pte_wr;
            ps_q  <= pte_sup;
            ctx_q <= cpu_ctx;
        end
    end

    // State and fill word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == S_REFILL && mem_ack) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Next state, array writes and CPU completion.
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_fault = 1'b0;
        cpu_rdata = '0;
        upd_we    = 1'b0;
        upd_tag   = lk_tag;
        dwe       = 1'b0;
        dw_sel    = rd_sel;
        dw_data   = wd_q;
        case (state_q)
            S_IDLE: begin
                if (cpu_req) state_d = S_LOOK;
            end
            S_LOOK: begin
                if (!cache_en) begin
                    state_d = S_MEM;
                end else if (hit) begin
                    if (viol) begin
                        cpu_ready = 1'b1;
                        cpu_fault = 1'b1;
                        state_d   = S_IDLE;
                    end else if (!we_q) begin
                        cpu_ready = 1'b1;
                        cpu_rdata = rd_word;
                        state_d   = S_IDLE;
                    end else begin
                        dwe     = 1'b1;
                        state_d = S_MEM;
                    end
                end else begin
                    upd_we        = 1'b1;
                    upd_tag.valid = 1'b0;
                    state_d       = we_q ? S_MEM : S_REFILL;
                end
            end
            S_REFILL: begin
                if (mem_ack) begin
                    dwe     = 1'b1;
                    dw_sel  = cnt_q;
                    dw_data = mem_rdata;
                    if (cnt_q == LAST) begin
                        upd_we  = 1'b1;
                        upd_tag = '{valid: 1'b1, ctx: ctx_q, wr: pw_q, sup: ps_q, tid: req_tid};
                        state_d = S_RESP;
                    end
                end
            end
            S_RESP: begin
                cpu_ready = 1'b1;
                cpu_rdata = rd_word;
                state_d   = S_IDLE;
            end
            S_MEM: begin
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    cpu_rdata = mem_rdata;
                    state_d   = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Memory port: line fill or single-word transfer.
    always_comb begin
        mem_req   = (state_q == S_REFILL) || (state_q == S_MEM);
        mem_we    = (state_q == S_MEM) && we_q;
        mem_wdata = wd_q;
        if (state_q == S_REFILL) begin
            mem_addr = {a_q[ADDR_W-1:OFS_W], cnt_q, {BYTE_W{1'b0}}};
        end else begin
            mem_addr = {a_q[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        end
    end

    a_r2_refill_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REFILL && mem_ack && cnt_q != LAST) |=>
            (mem_addr == $past(mem_addr) + ADDR_W'(4)));

    a_r2_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
            (mem_req && mem_addr == $past(mem_addr) && mem_we == $past(mem_we)));

    a_r5_fault_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fault |-> (cpu_ready && !upd_we && !dwe && !mem_req));

    a_r5_fault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fault |=> !cpu_fault);

    a_r6_bypass_no_array_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOOK && !cache_en) |-> (!upd_we && !dwe));
endmodule

// File: rtl/vac_cache.sv
// Top: virtually indexed, virtually tagged, direct-mapped write-through
// cache with tag control port and alias-check helper. Assumes tags are
// cleared through the control port before cache_en is raised.
module vac_cache
    import vac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [31:0]       cpu_addr,
    input  logic [31:0]       cpu_wdata,
    input  logic [2:0]        cpu_ctx,
    input  logic              cpu_super,
    input  logic              pte_wr,
    input  logic              pte_sup,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              cs_we,
    input  logic              cs_re,
    input  logic [11:0]       cs_idx,
    input  logic [31:0]       cs_wdata,
    output logic [31:0]       cs_rdata,
    input  logic [31:0]       alias_a,
    input  logic [31:0]       alias_b,
    output logic              alias_hit
);
    localparam logic [ADDR_W-1:0] ALIAS_MASK =
        ((ADDR_W'(1) << (IDX_LO + IDX_W)) - 1'b1) & ~((ADDR_W'(1) << PAGE_W) - 1'b1);

    logic [IDX_W-1:0]  line_idx;
    tag_t              lk_tag, upd_tag;
    logic              upd_we, dwe;
    logic [WSEL_W-1:0] rd_sel, dw_sel;
    logic [DATA_W-1:0] rd_word, dw_data;

    // Alias helper: index bits above the page offset differ.
    assign alias_hit = |((alias_a ^ alias_b) & ALIAS_MASK);

    vac_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ctx(cpu_ctx), .cpu_super(cpu_super),
        .pte_wr(pte_wr), .pte_sup(pte_sup),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_fault(cpu_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .line_idx(line_idx), .lk_tag(lk_tag), .upd_we(upd_we), .upd_tag(upd_tag),
        .rd_sel(rd_sel), .rd_word(rd_word), .dwe(dwe), .dw_sel(dw_sel),
        .dw_data(dw_data)
    );

    vac_tag_store u_tags (
        .clk(clk), .rst_n(rst_n), .lk_idx(line_idx), .lk_tag(lk_tag),
        .upd_we(upd_we), .upd_idx(line_idx), .upd_tag(upd_tag),
        .cs_we(cs_we), .cs_re(cs_re), .cs_idx(cs_idx), .cs_wdata(cs_wdata),
        .cs_rdata(cs_rdata)
    );

    vac_data_store u_data (
        .clk(clk), .idx(line_idx), .rd_sel(rd_sel), .rd_word(rd_word),
        .we(dwe), .wr_sel(dw_sel), .wr_word(dw_data)
    );

    a_r9_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!cpu_ready && !mem_req && !cpu_fault));
endmodule

// File: tb/vac_cache_tb.sv
`timescale 1ns/1ps
module vac_cache_tb;
    localparam int NL = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_super = 1'b0;
    logic        pte_wr = 1'b0, pte_sup = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [2:0]  cpu_ctx = '0;
    logic        cpu_ready, cpu_fault, mem_req, mem_we;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cs_we = 1'b0, cs_re = 1'b0;
    logic [11:0] cs_idx = '0;
    logic [31:0] cs_wdata = '0, cs_rdata;
    logic [31:0] alias_a = '0, alias_b = '0;
    logic        alias_hit;

    int checks = 0, fails = 0, ops = 0;
    bit finished = 0;
    logic [31:0] mmem [int unsigned];

    bit          m_v   [NL];
    bit [13:0]   m_tid [NL];
    bit [2:0]    m_ctx [NL];
    bit          m_w   [NL];
    bit          m_s   [NL];

    always #10 clk = ~clk;

    vac_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ctx(cpu_ctx), .cpu_super(cpu_super),
        .pte_wr(pte_wr), .pte_sup(pte_sup), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .cpu_fault(cpu_fault), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cs_we(cs_we), .cs_re(cs_re),
        .cs_idx(cs_idx), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata),
        .alias_a(alias_a), .alias_b(alias_b), .alias_hit(alias_hit)
    );

    function automatic logic [31:0] mem_init(logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] mem_get(logic [31:0] a);
        return mmem.exists(a) ? mmem[a] : mem_init(a);
    endfunction

    function automatic logic [31:0] exp_tag(int i);
        return {7'd0, m_ctx[i], m_w[i], m_s[i], m_v[i], 3'd0, m_tid[i], 2'd0};
    endfunction

    task automatic chk(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Memory model: acknowledge every other cycle, just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mem_req && !mem_ack) begin
                mem_ack = 1'b1;
                ops++;
                if (mem_we) begin
                    mmem[mem_addr] = mem_wdata;
                    mem_rdata = '0;
                end else begin
                    mem_rdata = mem_get(mem_addr);
                end
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic tag_write(int idx, logic [31:0] w);
        @(negedge clk);
        cs_we = 1'b1; cs_idx = 12'(idx); cs_wdata = w;
        @(negedge clk);
        cs_we = 1'b0;
    endtask

    task automatic tag_read(int idx, output logic [31:0] w);
        @(negedge clk);
        cs_re = 1'b1; cs_idx = 12'(idx);
        @(negedge clk);
        cs_re = 1'b0;
        w = cs_rdata;
    endtask

    // One CPU access, predicted from the model, checked and applied.
    task automatic access(bit we, logic [31:0] a, logic [31:0] wd, logic [2:0] ctx,
                          bit sup, bit pw, bit ps);
        int idx, start, nmem, t;
        bit hit, viol, got_fault;
        logic [31:0] got, exp_data;
        int exp_ops;
        bit exp_fault;
        string r;
        idx = int'(a[15:4]);
        hit  = m_v[idx] && m_tid[idx] == a[29:16] && m_ctx[idx] == ctx;
        viol = (we && !m_w[idx]) || (!sup && m_s[idx]);
        exp_data = mem_get(a);
        exp_fault = 0;
        if (!cache_en) begin r = "R6"; exp_ops = 1; end
        else if (hit && viol) begin r = "R5"; exp_ops = 0; exp_fault = 1; end
        else if (hit && !we) begin r = "R1"; exp_ops = 0; end
        else if (!we) begin r = "R2"; exp_ops = 4; end
        else if (hit) begin r = "R3"; exp_ops = 1; end
        else begin r = "R4"; exp_ops = 1; end
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_ctx = ctx;
        cpu_super = sup; pte_wr = pw; pte_sup = ps;
        start = ops;
        t = 0;
        got = '0; got_fault = 0;
        forever begin
            @(negedge clk);
            t++;
            if (cpu_ready) begin
                got = cpu_rdata; got_fault = cpu_fault;
                cpu_req = 1'b0;
                break;
            end
            if (t > 100) begin
                cpu_req = 1'b0;
                break;
            end
        end
        nmem = ops - start;
        chk(t <= 100, r, "completion", 32'(t), 32'd100);
        chk(nmem == exp_ops, r, "memory transactions", 32'(nmem), 32'(exp_ops));
        chk(got_fault == exp_fault, r, "fault flag", 32'(got_fault), 32'(exp_fault));
        if (!we && !exp_fault)
            chk(got == exp_data, r, "read data", got, exp_data);
        if (we && !exp_fault)
            chk(mem_get(a) == wd, r, "memory word after store", mem_get(a), wd);
        if (cache_en) begin
            if (!hit && !we) begin
                m_v[idx] = 1; m_tid[idx] = a[29:16]; m_ctx[idx] = ctx;
                m_w[idx] = pw; m_s[idx] = ps;
            end else if (!hit && we) begin
                m_v[idx] = 0;
            end
        end
    endtask

    task automatic tag_check(int idx, string r);
        logic [31:0] w;
        tag_read(idx, w);
        chk(w == exp_tag(idx), r, "tag word", w, exp_tag(idx));
    endtask

    function automatic logic [31:0] mk(int tid, int idx, int word);
        return {2'b00, 14'(tid), 12'(idx), 2'(word), 2'b00};
    endfunction

    initial begin
        logic [31:0] w;
        int pool [6] = '{12'h000, 12'h003, 12'h7A1, 12'hFFF, 12'h104, 12'h055};
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(!cpu_ready, "R9", "cpu_ready", 32'(cpu_ready), 0);
        chk(!mem_req, "R9", "mem_req", 32'(mem_req), 0);
        chk(!cpu_fault, "R9", "cpu_fault", 32'(cpu_fault), 0);
        chk(cs_rdata == 0, "R9", "cs_rdata", cs_rdata, 0);

        // R8: alias helper
        alias_a = 32'h0001_2000; alias_b = 32'h0001_3000; #1;
        chk(alias_hit == 1, "R8", "bit12 differs", 32'(alias_hit), 1);
        alias_b = 32'hFFFE_2FFF; #1;
        chk(alias_hit == 0, "R8", "only outside 15:12", 32'(alias_hit), 0);
        alias_b = 32'h0001_A000; #1;
        chk(alias_hit == 1, "R8", "bit15 differs", 32'(alias_hit), 1);
        alias_b = alias_a; #1;
        chk(alias_hit == 0, "R8", "equal", 32'(alias_hit), 0);

        // Clear all tags before enabling.
        for (int i = 0; i < NL; i++) tag_write(i, 32'h0);

        // R7: field layout and discarded unused bits
        tag_write(5, 32'hFFFF_FFFF);
        tag_read(5, w);
        chk(w == 32'h01F8_FFFC, "R7", "all-ones readback", w, 32'h01F8_FFFC);
        tag_write(5, 32'h0168_AAA8 | 32'hFE03_0001);
        tag_read(5, w);
        chk(w == 32'h0168_AAA8, "R7", "field readback", w, 32'h0168_AAA8);
        tag_write(5, 32'h0);
        tag_check(5, "R7");

        // R6: bypass while disabled, tags untouched
        access(0, mk(3, 5, 1), 0, 3'd1, 1, 1, 0);
        access(1, mk(3, 5, 2), 32'hDEAD_0001, 3'd1, 1, 1, 0);
        tag_check(5, "R6");
        cache_en = 1'b1;

        // R2 then R1: miss fills, second read hits
        access(0, mk(7, 9, 2), 0, 3'd2, 1, 1, 0);
        tag_check(9, "R2");
        access(0, mk(7, 9, 3), 0, 3'd2, 1, 1, 0);
        // R1: context mismatch misses
        access(0, mk(7, 9, 3), 0, 3'd4, 1, 1, 0);
        // R3: store hit updates cache and memory
        access(1, mk(7, 9, 0), 32'hCAFE_F00D, 3'd4, 1, 1, 0);
        access(0, mk(7, 9, 0), 0, 3'd4, 1, 1, 0);
        // R4: store miss invalidates, old line then misses
        access(1, mk(8, 9, 1), 32'h0BAD_BEEF, 3'd4, 1, 1, 0);
        tag_check(9, "R4");
        access(0, mk(7, 9, 0), 0, 3'd4, 1, 1, 0);
        // R5: read-only, supervisor-only line
        access(0, mk(2, 20, 0), 0, 3'd0, 1, 0, 1);
        access(1, mk(2, 20, 1), 32'h1111_2222, 3'd0, 1, 0, 1);
        access(0, mk(2, 20, 2), 0, 3'd0, 0, 1, 0);
        tag_check(20, "R5");
        access(0, mk(2, 20, 2), 0, 3'd0, 1, 1, 0);

        // Random mix over a few slots and tags
        for (int n = 0; n < 700; n++) begin
            int idx, tid;
            bit we;
            idx = pool[$urandom_range(0, 5)];
            tid = $urandom_range(0, 2);
            we  = ($urandom_range(0, 2) == 0);
            access(we, mk(tid, idx, $urandom_range(0, 3)), $urandom,
                   3'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                   ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0));
            if (n % 50 == 0) tag_check(idx, "R7");
        end
        finish_run();
    end
endmodule